// File: doc/BRIEF.md
# Interval Timer with Wrapping Comparator

This block keeps a free-running 64-bit base counter that steps once per clock and presents a slower interval count: the base count divided by four, truncated to 32 bits. Software reads the interval count and can arm a single alarm by writing a 32-bit compare value.

The compare value is given in interval-count units. On a write, the block converts it to base-clock units by shifting it left by two. It then folds the result into the low 34 bits of the current base count. If the resulting instant is not at least a guard distance (1000 base cycles) ahead of the current count, one full 34-bit epoch is added. This places the alarm at the next future instant whose low bits match the written value. When the base counter reaches that deadline, the block raises a one-cycle interrupt pulse and disarms. A further write always replaces whatever deadline is pending.

Top module: `interval_alarm_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the base counter, `count_o`, `deadline_o`, `armed_o` and `irq_o` are all zero after that edge.
- R2: Out of reset, the base counter increases by exactly one on every clock edge. `count_o` always shows base bits 33:2, so it advances once every four cycles.
- R3: A write (`wr_en` high at an edge, base count B at that edge) sets `deadline_o` after the edge. Bits 33:0 become `wr_value` shifted left by two, and bits 63:34 are taken from B.
- R4: If the deadline formed as in R3 is less than B+1000, then 2^34 is added to it, so the stored deadline is never less than B+1000.
- R5: A deadline formed exactly B+1000 is stored unchanged, and a deadline formed exactly B+999 receives the 2^34 addition.
- R6: `armed_o` is high in the cycle after any write.
- R7: While armed and with no write, the first edge at which the base count is greater than or equal to the deadline makes `irq_o` high for exactly one cycle and clears `armed_o` at the same edge.
- R8: After a pulse, no further pulse occurs until the next write, even though the base count stays past the deadline.
- R9: A write while armed replaces the pending deadline. Only the new deadline produces a pulse.
- R10: A write at the very edge where the old deadline would fire suppresses that pulse. The block stays armed with the new deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Program the compare value this cycle |
| wr_value | input | 32 | Compare value in interval-count units |
| count_o | output | 32 | Interval count (base count bits 33:2) |
| deadline_o | output | 64 | Active deadline in base-clock units |
| armed_o | output | 1 | A deadline is pending |
| irq_o | output | 1 | One-cycle alarm pulse |

## Verification
The assertions check these properties on every cycle: the per-edge increment of the base counter, the placement of the written value in the low 34 bits, the guard distance ahead of the write-time count, arming after a write, the single-cycle width of the pulse with disarming, and the absence of a pulse on a write edge. Only the bench's scenarios can show the following: that the guard boundary falls between 999 and 1000, that exactly one pulse is produced per arming, and that an overriding write leaves the old deadline silent. Because simulation cannot reach bit 34 of the counter, the epoch addition is shown through the stored deadline value rather than through a pulse.

// File: rtl/it_pkg.sv
// Shared constants for the interval alarm timer.
// Assumes the base counter is wider than the folded compare field.
package it_pkg;
    localparam int unsigned IT_BASE_W = 64;
    localparam int unsigned IT_CMP_W  = 32;
    localparam int unsigned IT_SHIFT  = 2;
    localparam int unsigned IT_GUARD  = 1000;
endpackage

// File: rtl/it_base_ctr.sv
// Free-running base counter with the divided interval-count view.
// Assumes BASE_W > CMP_W + SHIFT; the count wraps silently at the top.
module it_base_ctr #(
    parameter int unsigned BASE_W = 64,
    parameter int unsigned CMP_W  = 32,
    parameter int unsigned SHIFT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [BASE_W-1:0] base_o,
    output logic [CMP_W-1:0]  count_o
);
    localparam int unsigned FOLD_W = CMP_W + SHIFT;

    logic [BASE_W-1:0] base_q;

    // Step the base count every cycle; clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_q + 1'b1;
    end

    assign base_o  = base_q;
    assign count_o = base_q[FOLD_W-1:SHIFT];
endmodule

// File: rtl/it_alarm_calc.sv
// Combinational fold of a compare value into the base timeline.
// It replaces the low CMP_W+SHIFT bits of the base count with the scaled
// value and adds one epoch when the result lies closer than GUARD ahead.
module it_alarm_calc #(
    parameter int unsigned BASE_W = 64,
    parameter int unsigned CMP_W  = 32,
    parameter int unsigned SHIFT  = 2,
    parameter int unsigned GUARD  = 1000
) (
    input  logic [BASE_W-1:0] base_i,
    input  logic [CMP_W-1:0]  value_i,
    output logic [BASE_W-1:0] alarm_o
);
    localparam int unsigned FOLD_W = CMP_W + SHIFT;
    localparam logic [BASE_W-1:0] EPOCH     = BASE_W'(1) << FOLD_W;
    localparam logic [BASE_W-1:0] FOLD_MASK = EPOCH - 1'b1;

    logic [BASE_W-1:0] folded;
    logic [BASE_W-1:0] limit;

    // Splice the scaled value in, then push it one epoch on if too close.
    always_comb begin
        folded  = (base_i & ~FOLD_MASK) | (BASE_W'(value_i) << SHIFT);
        limit   = base_i + BASE_W'(GUARD);
        alarm_o = (folded < limit) ? folded + EPOCH : folded;
    end
endmodule

// File: rtl/it_deadline.sv
// Holds the active deadline, the armed flag and the alarm pulse.
// Assumes a write takes precedence over a firing in the same cycle.
module it_deadline #(
    parameter int unsigned BASE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BASE_W-1:0] alarm_i,
    input  logic [BASE_W-1:0] base_i,
    output logic [BASE_W-1:0] deadline_o,
    output logic              armed_o,
    output logic              irq_o
);
    logic [BASE_W-1:0] deadline_q;
    logic              armed_q;
    logic              irq_q;

    // Load a new deadline on write, else fire once when the count reaches it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deadline_q <= '0;
            armed_q    <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (wr_en) begin
                deadline_q <= alarm_i;
                armed_q    <= 1'b1;
            end else if (armed_q && (base_i >= deadline_q)) begin
                irq_q   <= 1'b1;
                armed_q <= 1'b0;
            end
        end
    end

    assign deadline_o = deadline_q;
    assign armed_o    = armed_q;
    assign irq_o      = irq_q;
endmodule

// File: rtl/interval_alarm_timer.sv
// Top of the interval timer: base counter, alarm fold and deadline state.
// Assumes one write port; reads of the count are direct from count_o.
module interval_alarm_timer
    import it_pkg::*;
#(
    parameter int unsigned BASE_W = IT_BASE_W,
    parameter int unsigned CMP_W  = IT_CMP_W,
    parameter int unsigned SHIFT  = IT_SHIFT,
    parameter int unsigned GUARD  = IT_GUARD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CMP_W-1:0]  wr_value,
    output logic [CMP_W-1:0]  count_o,
    output logic [BASE_W-1:0] deadline_o,
    output logic              armed_o,
    output logic              irq_o
);
    logic [BASE_W-1:0] base;
    logic [BASE_W-1:0] alarm;

    it_base_ctr #(.BASE_W(BASE_W), .CMP_W(CMP_W), .SHIFT(SHIFT)) u_ctr (
        .clk(clk), .rst_n(rst_n), .base_o(base), .count_o(count_o)
    );

    it_alarm_calc #(.BASE_W(BASE_W), .CMP_W(CMP_W), .SHIFT(SHIFT), .GUARD(GUARD)) u_calc (
        .base_i(base), .value_i(wr_value), .alarm_o(alarm)
    );

    it_deadline #(.BASE_W(BASE_W)) u_dl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .alarm_i(alarm),
        .base_i(base), .deadline_o(deadline_o), .armed_o(armed_o), .irq_o(irq_o)
    );
endmodule

// File: rtl/it_timer_chk.sv
// Property checker for the interval alarm timer, bound to the top.
module it_timer_chk #(
    parameter int unsigned BASE_W = 64,
    parameter int unsigned CMP_W  = 32,
    parameter int unsigned SHIFT  = 2,
    parameter int unsigned GUARD  = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CMP_W-1:0]  wr_value,
    input logic [BASE_W-1:0] base,
    input logic [BASE_W-1:0] deadline_o,
    input logic              armed_o,
    input logic              irq_o
);
    localparam int unsigned FOLD_W = CMP_W + SHIFT;

    logic past_ok;

    // Mark that at least one cycle has passed since reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (base == '0 && !armed_o && !irq_o && deadline_o == '0));

    // R2
    base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> base == $past(base) + 1'b1);

    // R3
    fold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en)) |->
            deadline_o[FOLD_W-1:0] == (FOLD_W'($past(wr_value)) << SHIFT));

    // R4
    guard_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en)) |-> deadline_o >= $past(base) + BASE_W'(GUARD));

    // R6
    arm_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en)) |-> armed_o);

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R7
    pulse_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !armed_o);

    // R10
    wr_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en)) |-> !irq_o);
endmodule

bind interval_alarm_timer it_timer_chk #(
    .BASE_W(BASE_W), .CMP_W(CMP_W), .SHIFT(SHIFT), .GUARD(GUARD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_value(wr_value),
    .base(base), .deadline_o(deadline_o), .armed_o(armed_o), .irq_o(irq_o)
);

// File: tb/test_interval_alarm_timer.sv
module test_interval_alarm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_value = '0;
    logic [31:0] count_o;
    logic [63:0] deadline_o;
    logic        armed_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    interval_alarm_timer i_interval_alarm_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_value(wr_value),
        .count_o(count_o), .deadline_o(deadline_o), .armed_o(armed_o), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference state
    longint unsigned m_base = 0;
    longint unsigned m_dl = 0;
    bit m_armed = 0;
    bit m_irq = 0;
    int pulses = 0;

    always @(posedge clk) begin
        longint unsigned cand;
        if (!rst_n) begin
            m_base = 0; m_dl = 0; m_armed = 0; m_irq = 0;
        end else begin
            m_irq = 0;
            if (wr_en) begin
                cand = (m_base & ~((64'd1 << 34) - 1)) + (longint'(wr_value) * 4);
                if (cand < m_base + 1000) cand = cand + (64'd1 << 34);
                m_dl = cand;
                m_armed = 1;
            end else if (m_armed && m_base >= m_dl) begin
                m_irq = 1;
                m_armed = 0;
            end
            m_base = m_base + 1;
        end
    end

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 count", {32'd0, count_o}, {32'd0, m_base[33:2]});
            check("R3 deadline", deadline_o, m_dl);
            check("R6 armed", {63'd0, armed_o}, {63'd0, m_armed});
            check("R7 irq", {63'd0, irq_o}, {63'd0, m_irq});
            if (irq_o) pulses++;
        end
    end

    task automatic write_val(logic [31:0] v);
        wr_en = 1'b1; wr_value = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        longint unsigned b;
        int p0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 count", {32'd0, count_o}, 64'd0);
        check("R1 deadline", deadline_o, 64'd0);
        check("R1 irq/armed", {62'd0, armed_o, irq_o}, 64'd0);
        rst_n = 1'b1;
        idle(9);
        // R2 count steps once per four cycles: base is 9 at this point
        check("R2 count after 9", {32'd0, count_o}, 64'd2);

        // R7 R8 basic alarm
        p0 = pulses;
        write_val(32'd600);
        check("R3 low bits", deadline_o, 64'd2400);
        while (m_base <= 2410) @(negedge clk);
        check("R7 one pulse", pulses - p0, 1);
        check("R7 disarmed", {63'd0, armed_o}, 64'd0);
        idle(300);
        check("R8 no repeat", pulses - p0, 1);

        // R5 boundary 999: needs an epoch
        while ((m_base + 999) % 4 != 0) @(negedge clk);
        b = m_base;
        write_val(32'((b + 999) / 4));
        check("R5 999 bumped", deadline_o, b + 999 + (64'd1 << 34));
        // R5 boundary 1000: stays
        while ((m_base + 1000) % 4 != 0) @(negedge clk);
        b = m_base;
        write_val(32'((b + 1000) / 4));
        check("R5 1000 kept", deadline_o, b + 1000);

        // R4 value in the past wraps into the next epoch
        b = m_base;
        write_val(32'd1);
        check("R4 wrap", deadline_o, 64'd4 + (64'd1 << 34));
        check("R6 armed after wr", {63'd0, armed_o}, 64'd1);

        // R9 override: far deadline replaced by a nearer one
        p0 = pulses;
        write_val(32'((m_base + 40000) / 4));
        idle(5);
        b = m_base;
        write_val(32'((b + 2000) / 4));
        while (m_base <= b + 2100) @(negedge clk);
        check("R9 new fires once", pulses - p0, 1);
        idle(40000);
        check("R9 old silent", pulses - p0, 1);

        // R10 write at the firing edge suppresses the pulse
        p0 = pulses;
        b = m_base;
        write_val(32'((b + 1500) / 4));
        while (m_base != m_dl) @(negedge clk);
        b = m_base;
        write_val(32'((b + 1200) / 4));
        check("R10 no pulse", {63'd0, irq_o}, 64'd0);
        check("R10 still armed", {63'd0, armed_o}, 64'd1);
        while (m_base <= b + 1300) @(negedge clk);
        check("R10 later pulse", pulses - p0, 1);

        // R1 reset mid-run clears everything
        rst_n = 1'b0;
        idle(2);
        check("R1 re-reset", {30'd0, count_o, armed_o, irq_o}, 64'd0);
        check("R1 re-reset deadline", deadline_o, 64'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule